// File: doc/BRIEF.md
# Parallel DAC host write sequencer

This block sits on the host side of an eight-channel, double-buffered digital-to-analog converter that has a parallel bus. It takes commands over a valid/ready handshake and turns each one into the converter's bus waveforms: an active-low chip select, an active-low write strobe, a 3-bit channel address, a 13-bit data word, four active-low load strobes (one for each channel pair) and an active-low clear. Every minimum pulse width and setup time is a cycle count. Each count is derived from a clock-period parameter as ceil(ns / CLK_NS), with a floor of one cycle.

Three kinds of command exist. A write places a word in the selected channel's input latch. A load command carries a 4-bit pair mask and moves the input latches of the chosen pairs into their output latches together. A clear drives the converter's clear pin. Several writes can be issued back to back and then committed by one load command. As an alternative, a write can carry an auto-load flag. This lowers its own pair's load strobe in the last strobe cycle and keeps it low for the full load width after the write strobe has gone high.

Top module: `dacseq_host`

## Requirements
- R1: While the synchronous active-high reset is applied and after it is released, the select, write, clear and all four load strobes are high, cmd_ready is 1, and the bus address and data are 0.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both 1. cmd_ready is 1 only when the sequencer is idle and is 0 from the cycle after acceptance. cmd_valid presented while cmd_ready is 0 has no effect on any output. cmd_op encodes 0 = write, 1 = load, 2 = clear; code 3 is taken and does nothing.
- R3: On acceptance of a write, dac_addr and dac_data take the command's values while all strobes stay high for N_AS = ceil(10/CLK_NS) cycles (1 at default), and only then does the strobe window open.
- R4: dac_cs_n and dac_wr_n fall on the same edge and rise on the same edge. They stay low for N_STB cycles, the largest of the select width, write width and data setup (each ceil(50/CLK_NS), so 5 at default).
- R5: dac_addr and dac_data do not change while dac_cs_n or dac_wr_n is low.
- R6: A load command drives dac_ld_n[i] low for N_LD = ceil(50/CLK_NS) cycles (5 at default) for each set mask bit i. Bit 0 is channels 0 and 1, bit 1 is channels 2 and 3, bit 2 is channels 4 and 5, and bit 3 is channels 6 and 7. All selected strobes share the same edges, and unselected strobes, select, write and clear stay high.
- R7: A clear command drives dac_clr_n low for N_CLR = ceil(100/CLK_NS) cycles (10 at default) with every other strobe high.
- R8: A write with cmd_autoload = 1 lowers the load strobe of pair cmd_addr[2:1] in the last cycle that select and write are low. It keeps that strobe low for N_LD further cycles after they rise, and leaves the other pairs high.
- R9: Each command ends with exactly one cycle in which all strobes are high and cmd_ready is 0. cmd_ready returns to 1 in the following cycle.
- R10: dac_addr and dac_data keep the last written address and data through load commands, clear commands and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command taken this edge if valid |
| cmd_op | input | 2 | 0 write, 1 load, 2 clear, 3 no operation |
| cmd_addr | input | 3 | Channel number for a write |
| cmd_data | input | 13 | Data word for a write |
| cmd_mask | input | 4 | Pair mask for a load command |
| cmd_autoload | input | 1 | Write also loads its own pair |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_addr | output | 3 | Channel address bus |
| dac_data | output | 13 | Data bus |
| dac_ld_n | output | 4 | Per-pair load strobes, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
The properties assume that reset is applied from the very first clock edge, so every register starts at a known value. They also assume that the clock period matches CLK_NS, because all widths are checked as exact cycle counts. Apart from that, the inputs are free. The properties must hold even when cmd_valid toggles while the block is busy. The stimulus therefore keeps reset high from time zero, uses the default period, and deliberately holds a conflicting command on the inputs during busy phases, so that the claim that such a command is ignored is actually tested.

// File: rtl/dacseq_pkg.sv
`timescale 1ns/1ps
package dacseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_LOAD,
    ST_CLEAR
  } seq_state_t;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;

  // Minimum time in ns turned into whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacseq_timer.sv
`timescale 1ns/1ps
// Down-counter that times the dwell in each sequencer state.
module dacseq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero_q,
  output logic             zero_next
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign zero_q    = (cnt_q == '0);
  assign zero_next = (cnt_d == '0);
endmodule

// File: rtl/dacseq_bus.sv
`timescale 1ns/1ps
// Address/data bus register: changes only when a write command is taken.
module dacseq_bus #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/dacseq_ldgen.sv
`timescale 1ns/1ps
// One registered load strobe per channel pair.
module dacseq_ldgen #(
  parameter int PAIRS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_load,
  input  logic             enter_last_strobe,
  input  logic             autoload,
  input  logic [PAIRS-1:0] mask,
  output logic [PAIRS-1:0] ld_n_q
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    logic low_d;
    assign low_d = mask[i] && (enter_load || (enter_last_strobe && autoload));
    always_ff @(posedge clk) begin
      if (rst) ld_n_q[i] <= 1'b1;
      else     ld_n_q[i] <= !low_d;
    end
  end
endmodule

// File: rtl/dacseq_host.sv
`timescale 1ns/1ps
module dacseq_host
  import dacseq_pkg::*;
#(
  parameter int CHANNELS   = 8,
  parameter int DATA_W     = 13,
  parameter int CLK_NS     = 10,
  parameter int T_CS_NS    = 50,
  parameter int T_WR_NS    = 50,
  parameter int T_DS_NS    = 50,
  parameter int T_AS_NS    = 10,
  parameter int T_LD_NS    = 50,
  parameter int T_CLR_NS   = 100,
  localparam int ADDR_W    = $clog2(CHANNELS),
  localparam int PAIRS     = CHANNELS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [PAIRS-1:0]  cmd_mask,
  input  logic              cmd_autoload,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic [ADDR_W-1:0] dac_addr,
  output logic [DATA_W-1:0] dac_data,
  output logic [PAIRS-1:0]  dac_ld_n,
  output logic              dac_clr_n
);
  localparam int N_AS  = ns2cyc(T_AS_NS, CLK_NS);
  localparam int N_STB = imax(imax(ns2cyc(T_CS_NS, CLK_NS), ns2cyc(T_WR_NS, CLK_NS)),
                              ns2cyc(T_DS_NS, CLK_NS));
  localparam int N_LD  = ns2cyc(T_LD_NS, CLK_NS);
  localparam int N_CLR = ns2cyc(T_CLR_NS, CLK_NS);
  localparam int N_MAX = imax(imax(N_AS, N_STB), imax(N_LD, N_CLR));
  localparam int CNT_W = $clog2(N_MAX + 1);

  seq_state_t       state_q, state_d;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero, tmr_zero_next;
  logic             al_q, al_d;
  logic [PAIRS-1:0] mask_q, mask_d, pair_sel;
  logic             ready_q, cs_n_q, wr_n_q, clr_n_q;

  assign accept   = cmd_valid && (state_q == ST_IDLE);
  assign pair_sel = PAIRS'(1) << cmd_addr[ADDR_W-1:1];

  // Per-command strobe plan, captured when the command is taken.
  always_comb begin
    al_d   = al_q;
    mask_d = mask_q;
    if (accept) begin
      al_d   = (cmd_op == OP_WRITE) && cmd_autoload;
      mask_d = (cmd_op == OP_WRITE) ? pair_sel : cmd_mask;
    end
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (cmd_op)
            OP_WRITE: begin state_d = ST_SETUP; tmr_val = CNT_W'(N_AS - 1);  end
            OP_LOAD:  begin state_d = ST_LOAD;  tmr_val = CNT_W'(N_LD - 1);  end
            OP_CLEAR: begin state_d = ST_CLEAR; tmr_val = CNT_W'(N_CLR - 1); end
            default:  state_d = ST_IDLE;
          endcase
          tmr_load = (state_d != ST_IDLE);
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_STB - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (al_q) begin
            state_d = ST_LOAD;
            tmr_val = CNT_W'(N_LD - 1);
          end else begin
            state_d = ST_RELEASE;
          end
        end
      end
      ST_LOAD, ST_CLEAR: begin
        if (tmr_zero) state_d = ST_RELEASE;
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  dacseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .zero_q    (tmr_zero),
    .zero_next (tmr_zero_next)
  );

  dacseq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .capture (accept && (cmd_op == OP_WRITE)),
    .addr_in (cmd_addr),
    .data_in (cmd_data),
    .addr_q  (dac_addr),
    .data_q  (dac_data)
  );

  dacseq_ldgen #(.PAIRS(PAIRS)) u_ldgen (
    .clk               (clk),
    .rst               (rst),
    .enter_load        (state_d == ST_LOAD),
    .enter_last_strobe ((state_d == ST_STROBE) && tmr_zero_next),
    .autoload          (al_d),
    .mask              (mask_d),
    .ld_n_q            (dac_ld_n)
  );

  // Registered strobes are decoded from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      cs_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      clr_n_q <= 1'b1;
      al_q    <= 1'b0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      cs_n_q  <= (state_d != ST_STROBE);
      wr_n_q  <= (state_d != ST_STROBE);
      clr_n_q <= (state_d != ST_CLEAR);
      al_q    <= al_d;
      mask_q  <= mask_d;
    end
  end

  assign cmd_ready = ready_q;
  assign dac_cs_n  = cs_n_q;
  assign dac_wr_n  = wr_n_q;
  assign dac_clr_n = clr_n_q;
endmodule

// File: rtl/dacseq_chk.sv
`timescale 1ns/1ps
module dacseq_chk
  import dacseq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 13,
  parameter int PAIRS    = 4,
  parameter int CLK_NS   = 10,
  parameter int T_CS_NS  = 50,
  parameter int T_WR_NS  = 50,
  parameter int T_DS_NS  = 50,
  parameter int T_LD_NS  = 50,
  parameter int T_CLR_NS = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              cs_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic [PAIRS-1:0]  ld_n,
  input logic              clr_n
);
  localparam int C_STB = imax(imax(ns2cyc(T_CS_NS, CLK_NS), ns2cyc(T_WR_NS, CLK_NS)),
                              ns2cyc(T_DS_NS, CLK_NS));
  localparam int C_LD  = ns2cyc(T_LD_NS, CLK_NS);
  localparam int C_CLR = ns2cyc(T_CLR_NS, CLK_NS);

  logic [15:0] wr_cnt, clr_cnt, ld_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt  <= '0;
      clr_cnt <= '0;
      ld_cnt  <= '0;
    end else begin
      wr_cnt  <= !wr_n  ? wr_cnt + 16'd1  : 16'd0;
      clr_cnt <= !clr_n ? clr_cnt + 16'd1 : 16'd0;
      ld_cnt  <= (ld_n != '1) ? ld_cnt + 16'd1 : 16'd0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && cs_n && wr_n && clr_n && (ld_n == '1)));

  p_cs_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $fell(wr_n));

  p_cs_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $rose(wr_n));

  p_wr_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (wr_cnt == 16'(C_STB)));

  p_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> ($stable(addr) && $stable(data)));

  p_bus_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !$fell(wr_n)) |-> ($stable(addr) && $stable(data)));

  p_ld_width_r6: assert property (@(posedge clk) disable iff (rst)
    ((ld_n == '1) && ($past(ld_n) != '1)) |-> (ld_cnt >= 16'(C_LD)));

  p_clr_alone_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (cs_n && wr_n && (ld_n == '1)));

  p_clr_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_n) |-> (clr_cnt == 16'(C_CLR)));

  p_ld_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_n) && ($past(ld_n) != '1)) |-> (ld_n == $past(ld_n)));

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cs_n && wr_n && clr_n && (ld_n == '1)));

  p_ready_low_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n || !clr_n) |-> !ready);
endmodule

bind dacseq_host dacseq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAIRS(PAIRS), .CLK_NS(CLK_NS),
  .T_CS_NS(T_CS_NS), .T_WR_NS(T_WR_NS), .T_DS_NS(T_DS_NS),
  .T_LD_NS(T_LD_NS), .T_CLR_NS(T_CLR_NS)
) u_chk (
  .clk(clk), .rst(rst), .ready(cmd_ready), .cs_n(dac_cs_n), .wr_n(dac_wr_n),
  .addr(dac_addr), .data(dac_data), .ld_n(dac_ld_n), .clr_n(dac_clr_n)
);

// File: tb/tb_dacseq_host.sv
`timescale 1ns/1ps
module tb_dacseq_host;
  localparam int CLK_PERIOD = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_AS  = cyc(10);
  localparam int E_STB = cyc(50);
  localparam int E_LD  = cyc(50);
  localparam int E_CLR = cyc(100);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_addr = '0;
  logic [12:0] cmd_data = '0;
  logic [3:0]  cmd_mask = '0;
  logic        cmd_autoload = 1'b0;
  logic        dac_cs_n, dac_wr_n, dac_clr_n;
  logic [2:0]  dac_addr;
  logic [12:0] dac_data;
  logic [3:0]  dac_ld_n;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacseq_host #(.CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_mask(cmd_mask), .cmd_autoload(cmd_autoload),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n), .dac_addr(dac_addr),
    .dac_data(dac_data), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n)
  );

  // Reference model: a queue of expected per-cycle output vectors.
  // Layout {ready, cs_n, wr_n, ld_n[3:0], clr_n, addr[2:0], data[12:0]}.
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [2:0]  m_addr = '0;
  logic [12:0] m_data = '0;

  function automatic logic [23:0] mk(input bit rdy, input bit cs, input bit wr,
                                     input logic [3:0] ld, input bit clr);
    return {rdy, cs, wr, ld, clr, m_addr, m_data};
  endfunction

  function automatic logic [23:0] actual();
    return {cmd_ready, dac_cs_n, dac_wr_n, dac_ld_n, dac_clr_n, dac_addr, dac_data};
  endfunction

  task automatic push(input logic [23:0] v, input string t, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  task automatic model_accept(input logic [1:0] op, input logic [2:0] a,
                              input logic [12:0] d, input logic [3:0] m, input bit al);
    logic [3:0] ldl;
    case (op)
      2'd0: begin
        m_addr = a;
        m_data = d;
        ldl = al ? ~(4'b0001 << a[2:1]) : 4'hF;
        push(mk(0, 1, 1, 4'hF, 1), "R3", E_AS);
        push(mk(0, 0, 0, 4'hF, 1), "R4 R5", E_STB - 1);
        push(mk(0, 0, 0, ldl, 1), al ? "R8" : "R4 R5", 1);
        if (al) push(mk(0, 1, 1, ldl, 1), "R8", E_LD);
        push(mk(0, 1, 1, 4'hF, 1), "R9", 1);
      end
      2'd1: begin
        push(mk(0, 1, 1, ~m, 1), "R6", E_LD);
        push(mk(0, 1, 1, 4'hF, 1), "R9", 1);
      end
      2'd2: begin
        push(mk(0, 1, 1, 4'hF, 0), "R7", E_CLR);
        push(mk(0, 1, 1, 4'hF, 1), "R9", 1);
      end
      default: ;
    endcase
  endtask

  task automatic check_vec(input logic [23:0] e, input string t);
    checks++;
    if (actual() !== e) begin
      failures++;
      $display("FAIL %s at %0t: got %h expected %h", t, $time, actual(), e);
    end
  endtask

  // One clock: compare at the falling edge, then drive for the next rising edge.
  // want=1 presents the real command when idle; junk=1 presents a conflicting
  // command while busy (R2: must be ignored).
  task automatic tick(input bit want, input bit junk, input logic [1:0] op,
                      input logic [2:0] a, input logic [12:0] d,
                      input logic [3:0] m, input bit al, output bit acc);
    logic [23:0] e;
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = mk(1, 1, 1, 4'hF, 1);
      t = "R2 R10";
    end
    check_vec(e, t);
    acc = 1'b0;
    if (want && e[23]) begin
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      cmd_mask = m; cmd_autoload = al;
      model_accept(op, a, d, m, al);
      acc = 1'b1;
    end else if (want && junk) begin
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = ~a; cmd_data = ~d;
      cmd_mask = 4'hF; cmd_autoload = 1'b1;
    end else begin
      cmd_valid = 1'b0;
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [2:0] a, input logic [12:0] d,
                     input logic [3:0] m, input bit al, input bit junk);
    bit acc = 1'b0;
    while (!acc) tick(1'b1, junk, op, a, d, m, al, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 2'd0, 3'd0, 13'd0, 4'd0, 1'b0, acc);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired: got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_vec({1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 3'd0, 13'd0}, "R1");
    end
    rst = 1'b0;
    idle(2);
    // R3 R4 R5 R9: plain writes, the second with a conflicting command held while busy (R2)
    run(2'd0, 3'd0, 13'h1ABC, 4'h0, 1'b0, 1'b0);
    run(2'd0, 3'd7, 13'h0001, 4'h0, 1'b0, 1'b1);
    run(2'd0, 3'd5, 13'h1FFF, 4'h0, 1'b0, 1'b1);
    idle(3);
    // R6: batch of writes committed by one simultaneous load of all pairs
    run(2'd0, 3'd2, 13'h0AAA, 4'h0, 1'b0, 1'b0);
    run(2'd0, 3'd3, 13'h1555, 4'h0, 1'b0, 1'b0);
    run(2'd1, 3'd0, 13'h0, 4'hF, 1'b0, 1'b1);
    run(2'd1, 3'd0, 13'h0, 4'b0101, 1'b0, 1'b0);
    run(2'd1, 3'd0, 13'h0, 4'b1000, 1'b0, 1'b0);
    idle(2);
    // R8: auto-load writes on pair 2 and pair 0
    run(2'd0, 3'd4, 13'h1000, 4'h0, 1'b1, 1'b0);
    run(2'd0, 3'd1, 13'h0123, 4'h0, 1'b1, 1'b1);
    run(2'd0, 3'd6, 13'h0F0F, 4'h0, 1'b1, 1'b0);
    // R7 R10: clear keeps the bus, and so does the no-op code
    run(2'd2, 3'd0, 13'h0, 4'h0, 1'b0, 1'b1);
    run(2'd3, 3'd2, 13'h0777, 4'h0, 1'b0, 1'b0);
    idle(4);
    run(2'd1, 3'd0, 13'h0, 4'h0, 1'b0, 1'b0);
    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule